// File: doc/BRIEF.md
# Burst Line-Fill Read Master

This block is the requesting end of a synchronous 32-bit bus. It fetches one cache line of four 32-bit words. The cache side hands it a start address, a function code and a "do not cache" hint through a valid/ready request port. The block then runs one bus cycle. It drives the address, read direction, size code, function code, a cache-inhibit output, address and data strobes, a one-clock cycle-start marker, a burst request and a data buffer enable.

The responder ends each transfer by asserting a synchronous termination input. That input is sampled on every rising edge, and any clock without it is a wait state. The first transfer turns into a burst only if the responder also asserts burst acknowledge in that same clock. A cache-inhibit input seen together with termination ends the cycle after that word. Every latched word is returned to the cache one clock after its termination edge. It comes with its position inside the line, a cacheable flag and a last-word flag. The words after the first arrive in wrap-around order within the 16-byte line.

Back-pressure rules: the request port obeys valid/ready. `req_valid` with its payload must stay stable until a clock edge where `req_ready` is high, and that edge accepts the request. The response port has no ready signal. The bus cannot be stalled by the cache, so the consumer must take every word in the clock where `rsp_valid` is high.

Top module: `burst_fill_master`

## Requirements
- R1: During and right after reset, `req_ready` is high and `bus_as`, `bus_ds`, `bus_buf_en`, `bus_start`, `bus_burst_req` and `rsp_valid` are low.
- R2: In the clock after an edge that accepts a request, `bus_as`, `bus_ds` and `bus_burst_req` are high. `bus_addr`, `bus_fc` and `bus_ci_out` hold the accepted address, function code and inhibit hint. `bus_rd` is 1 (read) and `bus_size` is 2'b00 (four bytes).
- R3: `bus_start` is high only in the first clock of a bus cycle and never during later transfers of a burst.
- R4: `bus_term` is sampled on each rising edge while the strobes are high. An edge without it produces no response and leaves every bus output unchanged. `bus_term` while the strobes are low is ignored.
- R5: A termination edge yields `rsp_valid` for exactly one clock, in the next clock, with `rsp_data` equal to `bus_data` sampled at that edge.
- R6: If the first termination comes without `bus_burst_ack`, the cycle ends as a single transfer. That word carries `rsp_last`=1, and the strobes are low in the next clock.
- R7: `bus_ci_in` high at any termination edge ends the cycle after that word. That word has `rsp_cacheable`=0 and `rsp_last`=1. Without it, `rsp_cacheable`=1.
- R8: A burst delivers four words. `rsp_idx` of the k-th word (k=0..3) is (address bits [3:2] + k) mod 4. The fourth word carries `rsp_last`=1, and the strobes drop in the next clock.
- R9: `bus_burst_req` stays high until the third termination edge and is low for the clock after it, so the fourth transfer is flagged as last. `bus_burst_ack` has no effect after the first transfer.
- R10: `bus_buf_en` is high exactly while the address strobe is high, and it drops in the clock after the final word is latched.
- R11: `req_ready` is low for the whole bus cycle. A request held valid meanwhile is accepted on the first edge after the strobes fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line-fill request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Byte address of the first word wanted |
| req_fc | input | 3 | Function code for the cycle |
| req_inhibit | input | 1 | Hint driven out as the cache-inhibit output |
| bus_addr | output | 32 | Bus address |
| bus_rd | output | 1 | Direction, 1 = read |
| bus_size | output | 2 | Size code, 2'b00 = four bytes |
| bus_fc | output | 3 | Function code |
| bus_ci_out | output | 1 | Cache-inhibit output |
| bus_start | output | 1 | Cycle-start marker, first clock only |
| bus_as | output | 1 | Address strobe, active high |
| bus_ds | output | 1 | Data strobe, active high |
| bus_burst_req | output | 1 | Burst request |
| bus_buf_en | output | 1 | External data buffer enable |
| bus_data | input | 32 | Read data from the responder |
| bus_term | input | 1 | Synchronous termination |
| bus_burst_ack | input | 1 | Burst acknowledge |
| bus_ci_in | input | 1 | Cache-inhibit input |
| rsp_valid | output | 1 | Latched word valid, one clock |
| rsp_data | output | 32 | Latched word |
| rsp_idx | output | 2 | Word position inside the line |
| rsp_cacheable | output | 1 | Word may be cached |
| rsp_last | output | 1 | Final word of the cycle |

## Verification
A wrong beat count or a lost end condition appears within one clock of the offending termination edge. The strobes stay high when they should have dropped, or fall early, and `rsp_last` or `rsp_idx` disagrees on that same word. A stale burst-request flag shows on `bus_burst_req` in the clock after the third transfer. A wrong idle/busy state shows right away as `req_ready` disagreeing with the strobes. The reference model tracks every output on every clock, so each such fault is reported in the first cycle where it becomes visible.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } bfm_state_e;

  localparam logic [1:0] SIZE_FOUR_BYTES = 2'b00;
endpackage

// File: rtl/bfm_beat_ctr.sv
module bfm_beat_ctr #(
  parameter int BEATS = 4,
  parameter int IDX_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] base_idx,
  input  logic             adv,
  output logic             first,
  output logic             at_drop,
  output logic             at_final,
  output logic [IDX_W-1:0] word_idx
);
  localparam logic [IDX_W-1:0] DROP_AT  = IDX_W'(BEATS - 2);
  localparam logic [IDX_W-1:0] FINAL_AT = IDX_W'(BEATS - 1);

  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else if (load) begin
      cnt_q  <= '0;
      base_q <= base_idx;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign first    = (cnt_q == '0);
  assign at_drop  = (cnt_q == DROP_AT);
  assign at_final = (cnt_q == FINAL_AT);
  assign word_idx = base_q + cnt_q;
endmodule

// File: rtl/bfm_ctrl.sv
module bfm_ctrl
  import bfm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic term,
  input  logic burst_ack,
  input  logic ci_in,
  input  logic first,
  input  logic at_drop,
  input  logic at_final,
  output logic req_ready,
  output logic accept,
  output logic beat_done,
  output logic finish,
  output logic as_o,
  output logic ds_o,
  output logic buf_en_o,
  output logic start_o,
  output logic breq_o
);
  bfm_state_e state_q;
  logic as_q, ds_q, buf_q, start_q, breq_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign beat_done = (state_q == ST_XFER) && term;
  assign finish    = beat_done && (ci_in || (first && !burst_ack) || at_final);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      as_q    <= 1'b0;
      ds_q    <= 1'b0;
      buf_q   <= 1'b0;
      start_q <= 1'b0;
      breq_q  <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept) begin
        state_q <= ST_XFER;
        as_q    <= 1'b1;
        ds_q    <= 1'b1;
        buf_q   <= 1'b1;
        breq_q  <= 1'b1;
      end else if (finish) begin
        state_q <= ST_IDLE;
        as_q    <= 1'b0;
        ds_q    <= 1'b0;
        buf_q   <= 1'b0;
        breq_q  <= 1'b0;
      end else if (beat_done && at_drop) begin
        breq_q <= 1'b0;
      end
    end
  end

  assign as_o     = as_q;
  assign ds_o     = ds_q;
  assign buf_en_o = buf_q;
  assign start_o  = start_q;
  assign breq_o   = breq_q;

  a_r10_bufen_tracks_as : assert property (@(posedge clk) disable iff (!rst_n)
    buf_q == as_q);
  a_r2_ds_tracks_as : assert property (@(posedge clk) disable iff (!rst_n)
    ds_q == as_q);
  a_r3_start_on_entry : assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> as_q && $past(req_valid && state_q == ST_IDLE));
endmodule

// File: rtl/bfm_rsp_reg.sv
module bfm_rsp_reg #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] data_in,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              cacheable_in,
  input  logic              last_in,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              cacheable_o,
  output logic              last_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o     <= 1'b0;
      data_o      <= '0;
      idx_o       <= '0;
      cacheable_o <= 1'b0;
      last_o      <= 1'b0;
    end else begin
      valid_o <= capture;
      if (capture) begin
        data_o      <= data_in;
        idx_o       <= idx_in;
        cacheable_o <= cacheable_in;
        last_o      <= last_in;
      end
    end
  end
endmodule

// File: rtl/burst_fill_master.sv
module burst_fill_master
  import bfm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FC_W   = 3,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [FC_W-1:0]   req_fc,
  input  logic              req_inhibit,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic [1:0]        bus_size,
  output logic [FC_W-1:0]   bus_fc,
  output logic              bus_ci_out,
  output logic              bus_start,
  output logic              bus_as,
  output logic              bus_ds,
  output logic              bus_burst_req,
  output logic              bus_buf_en,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_term,
  input  logic              bus_burst_ack,
  input  logic              bus_ci_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [$clog2(BEATS)-1:0] rsp_idx,
  output logic              rsp_cacheable,
  output logic              rsp_last
);
  localparam int IDX_W    = $clog2(BEATS);
  localparam int BYTE_LSB = $clog2(DATA_W / 8);

  logic accept, beat_done, finish;
  logic first, at_drop, at_final;
  logic [IDX_W-1:0] word_idx;
  logic [ADDR_W-1:0] addr_q;
  logic [FC_W-1:0] fc_q;
  logic ci_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      fc_q   <= '0;
      ci_q   <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      fc_q   <= req_fc;
      ci_q   <= req_inhibit;
    end
  end

  assign bus_addr   = addr_q;
  assign bus_fc     = fc_q;
  assign bus_ci_out = ci_q;
  assign bus_rd     = 1'b1;
  assign bus_size   = SIZE_FOUR_BYTES;

  bfm_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .term      (bus_term),
    .burst_ack (bus_burst_ack),
    .ci_in     (bus_ci_in),
    .first     (first),
    .at_drop   (at_drop),
    .at_final  (at_final),
    .req_ready (req_ready),
    .accept    (accept),
    .beat_done (beat_done),
    .finish    (finish),
    .as_o      (bus_as),
    .ds_o      (bus_ds),
    .buf_en_o  (bus_buf_en),
    .start_o   (bus_start),
    .breq_o    (bus_burst_req)
  );

  bfm_beat_ctr #(.BEATS(BEATS), .IDX_W(IDX_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .base_idx (req_addr[BYTE_LSB +: IDX_W]),
    .adv      (beat_done),
    .first    (first),
    .at_drop  (at_drop),
    .at_final (at_final),
    .word_idx (word_idx)
  );

  bfm_rsp_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rsp (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (beat_done),
    .data_in      (bus_data),
    .idx_in       (word_idx),
    .cacheable_in (!bus_ci_in),
    .last_in      (finish),
    .valid_o      (rsp_valid),
    .data_o       (rsp_data),
    .idx_o        (rsp_idx),
    .cacheable_o  (rsp_cacheable),
    .last_o       (rsp_last)
  );

  a_r5_rsp_follows_term : assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_term && bus_as));
  a_r6_single_when_no_ack : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_term && first && !bus_burst_ack) |=> !bus_as && rsp_last);
  a_r7_inhibit_aborts : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_term && bus_ci_in) |=> !bus_as && !rsp_cacheable && rsp_last);
  a_r9_breq_drops_before_last : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_term && at_drop && !first && !bus_ci_in) |=> bus_as && !bus_burst_req);
  a_r11_ready_only_idle : assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_as);
endmodule

// File: tb/tb_burst_fill_master.sv
`timescale 1ns/1ps
module tb_burst_fill_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_fc = '0;
  logic        req_inhibit = 1'b0;
  logic [31:0] bus_addr;
  logic        bus_rd;
  logic [1:0]  bus_size;
  logic [2:0]  bus_fc;
  logic        bus_ci_out, bus_start, bus_as, bus_ds, bus_burst_req, bus_buf_en;
  logic [31:0] bus_data = '0;
  logic        bus_term = 1'b0, bus_burst_ack = 1'b0, bus_ci_in = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [1:0]  rsp_idx;
  logic        rsp_cacheable, rsp_last;

  always #2 clk = ~clk;

  burst_fill_master dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_fc(req_fc), .req_inhibit(req_inhibit),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_size(bus_size), .bus_fc(bus_fc),
    .bus_ci_out(bus_ci_out), .bus_start(bus_start), .bus_as(bus_as), .bus_ds(bus_ds),
    .bus_burst_req(bus_burst_req), .bus_buf_en(bus_buf_en),
    .bus_data(bus_data), .bus_term(bus_term), .bus_burst_ack(bus_burst_ack),
    .bus_ci_in(bus_ci_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_idx(rsp_idx),
    .rsp_cacheable(rsp_cacheable), .rsp_last(rsp_last)
  );

  int n_chk = 0;
  int n_err = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Responder settings
  int  wait_n = 0;
  bit  ack_first = 1'b1;
  bit  ack_later = 1'b1;
  int  ci_beat = -1;
  bit  idle_noise = 1'b0;
  int  rb = 0;
  int  wcnt = 0;
  logic [31:0] dctr = 32'hA5000000;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_as) begin
        if (wcnt < wait_n) begin
          bus_term = 1'b0;
          bus_burst_ack = ~ack_first;
          bus_ci_in = 1'b1;
          wcnt++;
        end else begin
          bus_term = 1'b1;
          bus_burst_ack = (rb == 0) ? ack_first : ack_later;
          bus_ci_in = (rb == ci_beat);
          dctr = dctr + 32'h00010203;
          bus_data = dctr;
          wcnt = 0;
          rb++;
        end
      end else begin
        bus_term = idle_noise;
        bus_burst_ack = idle_noise;
        bus_ci_in = 1'b0;
        rb = 0;
        wcnt = 0;
      end
    end
  end

  // Behavioural reference model
  bit          m_busy = 0, m_start = 0, m_breq = 0, m_inh = 0;
  logic [31:0] m_addr = 0;
  logic [2:0]  m_fc = 0;
  int          m_k = 0;
  bit          m_rv = 0, m_cach = 0, m_last = 0;
  logic [31:0] m_data = 0;
  int          m_idx = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_start = 0; m_breq = 0; m_rv = 0; m_k = 0;
    end else begin
      m_rv = 0;
      m_start = 0;
      if (!m_busy) begin
        if (req_valid) begin
          m_busy = 1; m_start = 1; m_breq = 1; m_k = 0;
          m_addr = req_addr; m_fc = req_fc; m_inh = req_inhibit;
        end
      end else if (bus_term) begin
        bit fin;
        m_rv = 1;
        m_data = bus_data;
        m_idx = (int'(m_addr[3:2]) + m_k) % 4;
        m_cach = !bus_ci_in;
        fin = bus_ci_in || (m_k == 0 && !bus_burst_ack) || (m_k == 3);
        m_last = fin;
        if (fin) begin
          m_busy = 0; m_breq = 0;
        end else begin
          if (m_k == 2) m_breq = 0;
          m_k++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R11 req_ready", req_ready, !m_busy);
      chk("R4 bus_as", bus_as, m_busy);
      chk("R2 bus_ds", bus_ds, m_busy);
      chk("R10 bus_buf_en", bus_buf_en, m_busy);
      chk("R3 bus_start", bus_start, m_start);
      chk("R9 bus_burst_req", bus_burst_req, m_breq);
      chk("R2 bus_rd", bus_rd, 1);
      chk("R2 bus_size", bus_size, 0);
      if (m_busy) begin
        chk("R2 bus_addr", bus_addr, m_addr);
        chk("R2 bus_fc", bus_fc, m_fc);
        chk("R2 bus_ci_out", bus_ci_out, m_inh);
      end
      chk("R5 rsp_valid", rsp_valid, m_rv);
      if (m_rv) begin
        chk("R5 rsp_data", rsp_data, m_data);
        chk("R8 rsp_idx", rsp_idx, m_idx);
        chk("R7 rsp_cacheable", rsp_cacheable, m_cach);
        chk("R6 rsp_last", rsp_last, m_last);
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [2:0] fc, input bit inh);
    req_valid = 1'b1;
    req_addr = a;
    req_fc = fc;
    req_inhibit = inh;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 req_ready", req_ready, 1);
    chk("R1 bus_as", bus_as, 0);
    chk("R1 bus_ds", bus_ds, 0);
    chk("R1 bus_buf_en", bus_buf_en, 0);
    chk("R1 bus_start", bus_start, 0);
    chk("R1 bus_burst_req", bus_burst_req, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {bus_as, req_ready, rsp_valid}, 3'b010);
    chk_on = 1'b1;

    // R8: full burst from word 0, no wait states
    wait_n = 0; ack_first = 1; ack_later = 1; ci_beat = -1;
    issue(32'h0000_1000, 3'd6, 1'b0);
    wait_idle();

    // R8 wrap from word 2, R4 wait states
    wait_n = 2;
    issue(32'h0000_2008, 3'd5, 1'b1);
    wait_idle();

    // R6: no acknowledge -> single transfer
    wait_n = 1; ack_first = 0;
    issue(32'h0000_300C, 3'd2, 1'b0);
    wait_idle();

    // R7: inhibit on first transfer with acknowledge
    wait_n = 0; ack_first = 1; ci_beat = 0;
    issue(32'h0000_4004, 3'd1, 1'b0);
    wait_idle();

    // R7: inhibit on third transfer
    wait_n = 1; ci_beat = 2;
    issue(32'h0000_5004, 3'd6, 1'b0);
    wait_idle();

    // R9: later acknowledge low has no effect
    wait_n = 1; ci_beat = -1; ack_later = 0;
    issue(32'h0000_600C, 3'd5, 1'b1);
    wait_idle();

    // R11 back-to-back with held request, R4 idle termination noise
    wait_n = 0; ack_later = 1; idle_noise = 1;
    issue(32'h0000_7004, 3'd2, 1'b0);
    issue(32'h0000_8008, 3'd1, 1'b1);
    wait_idle();
    idle_noise = 0;
    repeat (3) @(negedge clk);
    chk("R4 idle noise ignored", {bus_as, rsp_valid}, 2'b00);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end
endmodule